// File: doc/BRIEF.md
# Table-Driven Wall-Following Walker Controller

This block steers a small walking robot out of a maze by keeping its right antenna against a wall. Two contact sensors report whether the left or the right antenna is touching something. The block answers with three motion strobes: take one step forward, turn left by a small fixed angle, or turn right by a small fixed angle.

The whole control law sits in one constant lookup table of 16 words by 5 bits. The table is indexed by the 2-bit current state together with the two sensor bits. Each word holds the next state and the three motion commands. A 2-bit state register updates on every rising clock edge. The motion strobes come only from the registered state, so each one is steady for a full cycle. A synchronous, active-high reset puts the walker in its searching state.

Top module: `antenna_wall_follower`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is Searching (code 00). Its outputs are `step_fwd`=1, `turn_left`=0, `turn_right`=0.
- R2: In Searching the block drives `step_fwd` alone. It stays in Searching while neither antenna touches. If either antenna touches, it moves to Backing (code 01) at the next edge.
- R3: In Backing the block drives `turn_left` alone. It stays in Backing while either antenna touches. When both antennae are clear, it moves to Seeking (code 10).
- R4: In Seeking the block drives `step_fwd` and `turn_right` together. It stays in Seeking when neither antenna touches. A right-only touch moves it to Hugging (code 11).
- R5: In Hugging the block drives `step_fwd` and `turn_left` together. A right-only touch keeps it in Hugging. No contact returns it to Seeking.
- R6: In Seeking or Hugging, a left touch moves the block to Backing at the next edge, whatever the right antenna reports.
- R7: The outputs depend on the registered state alone. A change on the sensor inputs between edges has no effect on them until the next rising edge.
- R8: `turn_left` and `turn_right` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to Searching |
| touch_left | input | 1 | 1 while the left antenna touches an obstacle |
| touch_right | input | 1 | 1 while the right antenna touches an obstacle |
| step_fwd | output | 1 | Step forward command |
| turn_left | output | 1 | Small left turn command |
| turn_right | output | 1 | Small right turn command |

## Verification
The properties assume that the sensor bits are settled and known at every rising edge. They also assume that reset is held for at least one edge before the first checked cycle, because the state is only known from then on. The bench changes the sensor bits only on falling edges and holds reset across two edges at start-up. This keeps every sampled value defined. The bench leaves the sensors briefly glitching between edges only in the scenario that checks that such changes are ignored.

// File: rtl/antenna_wall_follower.sv
module antenna_wall_follower (
  input  logic clk,
  input  logic rst,
  input  logic touch_left,
  input  logic touch_right,
  output logic step_fwd,
  output logic turn_left,
  output logic turn_right
);
  localparam int STATE_W = 2;
  localparam int SENSE_W = 2;
  localparam int CMD_W   = 3;
  localparam int ADDR_W  = STATE_W + SENSE_W;
  localparam int WORD_W  = STATE_W + CMD_W;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef enum logic [STATE_W-1:0] {
    SEARCHING = 2'b00,
    BACKING   = 2'b01,
    SEEKING   = 2'b10,
    HUGGING   = 2'b11
  } walk_state_e;

  // word layout: {next_state, turn_right, turn_left, step_fwd}
  function automatic logic [WORD_W-1:0] law(input logic [ADDR_W-1:0] a);
    logic [STATE_W-1:0] nx;
    logic [CMD_W-1:0]   cmd;
    logic l, r;
    l = a[1];
    r = a[0];
    case (a[ADDR_W-1 -: STATE_W])
      SEARCHING: begin
        cmd = 3'b001;
        nx  = (l | r) ? BACKING : SEARCHING;
      end
      BACKING: begin
        cmd = 3'b010;
        nx  = (l | r) ? BACKING : SEEKING;
      end
      SEEKING: begin
        cmd = 3'b101;
        nx  = l ? BACKING : (r ? HUGGING : SEEKING);
      end
      default: begin
        cmd = 3'b011;
        nx  = l ? BACKING : (r ? HUGGING : SEEKING);
      end
    endcase
    return {nx, cmd};
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = law(ADDR_W'(i));
  end

  walk_state_e state;
  logic [STATE_W-1:0] next_state;
  logic [CMD_W-1:0]   cmd;

  assign next_state = rom[{state, touch_left, touch_right}][WORD_W-1 -: STATE_W];
  assign cmd        = rom[{state, {SENSE_W{1'b0}}}][CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) state <= SEARCHING;
    else     state <= walk_state_e'(next_state);
  end

  assign step_fwd   = cmd[0];
  assign turn_left  = cmd[1];
  assign turn_right = cmd[2];
endmodule

module wall_follower_props (
  input logic clk,
  input logic rst,
  input logic touch_left,
  input logic touch_right,
  input logic step_fwd,
  input logic turn_left,
  input logic turn_right
);
  logic in_search, in_back, in_seek, in_hug;
  assign in_search = step_fwd && !turn_left && !turn_right;
  assign in_back   = !step_fwd && turn_left && !turn_right;
  assign in_seek   = step_fwd && turn_right;
  assign in_hug    = step_fwd && turn_left;

  assert_reset_searching_R1: assert property (@(posedge clk)
    rst |=> (step_fwd && !turn_left && !turn_right));

  assert_search_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    (in_search && (touch_left || touch_right)) |=> in_back);

  assert_back_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (in_back && !touch_left && !touch_right) |=> in_seek);

  assert_seek_to_hug_R4: assert property (@(posedge clk) disable iff (rst)
    (in_seek && touch_right && !touch_left) |=> in_hug);

  assert_hug_to_seek_R5: assert property (@(posedge clk) disable iff (rst)
    (in_hug && !touch_left && !touch_right) |=> in_seek);

  assert_left_hit_back_R6: assert property (@(posedge clk) disable iff (rst)
    ((in_seek || in_hug) && touch_left) |=> in_back);

  assert_turns_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(turn_left && turn_right));
endmodule

bind antenna_wall_follower wall_follower_props u_props (.*);

// File: tb/sim_antenna_wall_follower.sv
module sim_antenna_wall_follower;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic touch_left = 1'b0;
  logic touch_right = 1'b0;
  logic step_fwd, turn_left, turn_right;

  int checks = 0;
  int fails = 0;
  logic [1:0] exp_state = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  antenna_wall_follower u0 (
    .clk(clk), .rst(rst), .touch_left(touch_left), .touch_right(touch_right),
    .step_fwd(step_fwd), .turn_left(turn_left), .turn_right(turn_right)
  );

  function automatic logic [1:0] model_next(input logic [1:0] s, input logic l, input logic r);
    case (s)
      2'b00: return (l || r) ? 2'b01 : 2'b00;
      2'b01: return (l || r) ? 2'b01 : 2'b10;
      default: begin
        if (l) return 2'b01;
        else if (r) return 2'b11;
        else return 2'b10;
      end
    endcase
  endfunction

  // {turn_right, turn_left, step_fwd}
  function automatic logic [2:0] model_cmd(input logic [1:0] s);
    case (s)
      2'b00: return 3'b001;
      2'b01: return 3'b010;
      2'b10: return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  task automatic check_out(input string req);
    logic [2:0] got, want;
    got  = {turn_right, turn_left, step_fwd};
    want = model_cmd(exp_state);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: outputs {tr,tl,f} actual %b expected %b", req, got, want);
    end
  endtask

  task automatic apply(input logic l, input logic r, input string req);
    touch_left  = l;
    touch_right = r;
    @(posedge clk);
    exp_state = model_next(exp_state, l, r);
    @(negedge clk);
    check_out(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    touch_left = 1'b0;
    touch_right = 1'b0;
    @(posedge clk);
    @(posedge clk);
    exp_state = 2'b00;
    @(negedge clk);
    check_out("R1");
    rst = 1'b0;
  endtask

  task automatic test_searching();
    apply(0, 0, "R2");
    apply(0, 0, "R2");
    apply(0, 1, "R2");
    do_reset();
    apply(1, 0, "R2");
    do_reset();
    apply(1, 1, "R2");
  endtask

  task automatic test_backing();
    apply(1, 0, "R3");
    apply(0, 1, "R3");
    apply(1, 1, "R3");
    apply(0, 0, "R3");
  endtask

  task automatic test_wall();
    apply(0, 0, "R4");
    apply(0, 0, "R4");
    apply(0, 1, "R4");
    apply(0, 1, "R5");
    apply(0, 0, "R5");
    apply(0, 1, "R5");
    apply(1, 1, "R6");
    apply(0, 0, "R6");
    apply(1, 0, "R6");
    apply(0, 0, "R6");
    apply(0, 1, "R6");
    apply(1, 0, "R6");
    apply(0, 0, "R6");
    apply(1, 1, "R6");
  endtask

  task automatic test_glitch();
    apply(0, 0, "R7");
    touch_left = 1'b1;
    #1 check_out("R7");
    touch_right = 1'b1;
    #1 check_out("R7");
    touch_left = 1'b0;
    touch_right = 1'b0;
    @(posedge clk);
    exp_state = model_next(exp_state, 1'b0, 1'b0);
    @(negedge clk);
    check_out("R7");
  endtask

  task automatic test_turn_excl();
    for (int i = 0; i < 16; i++) begin
      apply(i[1], i[0], "R8");
      checks++;
      if (turn_left && turn_right) begin
        fails++;
        $display("FAIL R8: tl=%b tr=%b expected not both", turn_left, turn_right);
      end
    end
  endtask

  task automatic test_reset_midrun();
    apply(0, 1, "R1");
    do_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    test_searching();
    test_backing();
    test_wall();
    test_glitch();
    test_turn_excl();
    test_reset_midrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule